// File: doc/BRIEF.md
# Coprocessor Low-Latency Memory Window

This unit sits beside a CPU core and exposes a small side memory through selector-addressed register moves. The core issues a move-to (a selector plus a 64-bit value) or a move-from (a selector only), and the unit answers a move-from one cycle later with a registered result and a valid pulse. There are two access sets, and each has its own 64-bit data register. A transfer is started by writing an address to a trigger selector. A read trigger fills the set's data register from memory. A write trigger stores the set's data register into memory.

Two separate stores back the window. The narrow store keeps 36-bit entries, and a narrow read returns them with an even-parity bit generated on the way out. The wide store keeps full 64-bit entries. Each store has one valid bit per entry, and all valid bits clear on reset, so an entry that has never been written reads as zero. The entry index is taken from the low bits of the written address. A status word can be read through the same selector as the set-0 narrow read trigger: a move-to on that selector starts a narrow read, and a move-from on it returns the status word. The status word comes up as 1 after reset.

If both strobes are raised in the same cycle with a legal selector, both take effect, and the move-from returns the value as it was before that cycle's move-to.

Top module: `lwin_top`

## Requirements
- R1: Selectors are decoded as base 0x400 plus 8 × set (set 0 or 1) plus a function code. The function codes are: 0 narrow read trigger, 1 narrow write trigger, 2 data register, 4 wide read trigger, 5 wide write trigger.
- R2: A move-to on a data selector (0x402, 0x40A) loads that set's data register. A move-from on that selector returns the register.
- R3: A narrow write trigger stores only bits 35:0 of the set's data register. Higher bits are dropped.
- R4: A narrow read returns the stored 36 bits in bits 35:0, the XOR of those bits in bit 36, and zeros in bits 63:37.
- R5: Wide read and write triggers move all 64 bits unchanged.
- R6: The narrow store and the wide store are independent. A write to one never changes what the other returns at the same address.
- R7: After reset, an entry that has never been written reads as zero from either store.
- R8: A move-from on 0x400 returns the status word, which is 1 after reset, and never returns memory data.
- R9: A move-from result appears on rdata with rvalid high for exactly one cycle, one clock after the strobe. A move-from in the cycle right after a trigger sees the updated data register. After reset, rdata, rvalid and illegal_sel are zero.
- R10: A move-to on a selector outside the map (function codes 3, 6, 7, or outside 0x400 to 0x40F) pulses illegal_sel for one cycle and changes no state.
- R11: The two sets have separate data registers and share both stores.
- R12: The store index is the low log2(DEPTH) bits of the written address. Higher address bits are ignored.
- R13: A move-from on any selector other than 0x400, 0x402 and 0x40A pulses illegal_sel, gives no rvalid, and leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_en | input | 1 | Move-to strobe |
| mf_en | input | 1 | Move-from strobe |
| sel | input | 12 | Register selector |
| wdata | input | 64 | Move-to value (data word or address) |
| rdata | output | 64 | Registered move-from result |
| rvalid | output | 1 | One-cycle pulse marking a move-from result |
| illegal_sel | output | 1 | One-cycle pulse for an unmapped selector |

## Verification
Every store entry is first written with a distinct multiplicative pattern through alternating sets. The patterns carry high bits and varied parity, so truncation and parity errors show up. All entries are then read back through the opposite set, which separates per-set data registers from the shared stores.

Wide-only writes followed by narrow reads at the same address show whether the two stores are kept apart. Out-of-range addresses show whether the index is taken from the low bits. Back-to-back trigger and move-from pairs check the one-cycle turnaround. Unmapped and write-only selectors, followed by a data read-back, confirm that illegal accesses change nothing.

// File: rtl/lwin_pkg.sv
package lwin_pkg;
  typedef enum logic [2:0] {
    LW_NONE,
    LW_NRD,
    LW_NWR,
    LW_DATA,
    LW_WRD,
    LW_WWR,
    LW_STAT
  } lw_op_e;
endpackage

// File: rtl/lwin_decode.sv
module lwin_decode
  import lwin_pkg::*;
#(
  parameter int SEL_W    = 12,
  parameter logic [SEL_W-1:0] SEL_BASE = 12'h400,
  parameter int NUM_SETS = 2,
  parameter int SET_W    = 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             mt_en,
  input  logic             mf_en,
  output lw_op_e           op_mt,
  output lw_op_e           op_mf,
  output logic [SET_W-1:0] set_idx,
  output logic             illegal
);
  localparam logic [SEL_W-1:0] SPAN = SEL_W'(8 * NUM_SETS);

  logic [SEL_W-1:0] off;
  logic             in_range;
  logic [2:0]       func;

  always_comb begin
    off      = sel - SEL_BASE;
    in_range = (sel >= SEL_BASE) && (off < SPAN);
    func     = off[2:0];
    set_idx  = off[3 +: SET_W];
  end

  always_comb begin
    op_mt = LW_NONE;
    if (in_range) begin
      case (func)
        3'd0:    op_mt = LW_NRD;
        3'd1:    op_mt = LW_NWR;
        3'd2:    op_mt = LW_DATA;
        3'd4:    op_mt = LW_WRD;
        3'd5:    op_mt = LW_WWR;
        default: op_mt = LW_NONE;
      endcase
    end
  end

  always_comb begin
    op_mf = LW_NONE;
    if (sel == SEL_BASE)
      op_mf = LW_STAT;
    else if (in_range && func == 3'd2)
      op_mf = LW_DATA;
  end

  assign illegal = (mt_en && op_mt == LW_NONE) || (mf_en && op_mf == LW_NONE);
endmodule

// File: rtl/lwin_store.sv
module lwin_store #(
  parameter int W      = 36,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= '0;
    else if (wr_en)
      valid_q[wr_addr] <= 1'b1;
  end

  assign rd_data = valid_q[rd_addr] ? mem[rd_addr] : '0;
endmodule

// File: rtl/lwin_narrow_pack.sv
module lwin_narrow_pack #(
  parameter int NARROW_W = 36,
  parameter int DATA_W   = 64
) (
  input  logic [NARROW_W-1:0] raw,
  output logic [DATA_W-1:0]   packed_word
);
  always_comb begin
    packed_word               = '0;
    packed_word[NARROW_W-1:0] = raw;
    packed_word[NARROW_W]     = ^raw;
  end
endmodule

// File: rtl/lwin_top.sv
module lwin_top
  import lwin_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 36,
  parameter int DEPTH    = 16,
  parameter int NUM_SETS = 2,
  parameter int SEL_W    = 12,
  parameter logic [SEL_W-1:0]  SEL_BASE     = 12'h400,
  parameter logic [DATA_W-1:0] STATUS_RESET = 64'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mt_en,
  input  logic              mf_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              illegal_sel
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  lw_op_e            op_mt, op_mf;
  logic [SET_W-1:0]  set_idx;
  logic              illegal;
  logic              do_mt, do_mf;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data_q [NUM_SETS];
  logic [DATA_W-1:0] cur_data;
  logic [DATA_W-1:0] status_q;
  logic [NARROW_W-1:0] n_rd;
  logic [DATA_W-1:0]   w_rd;
  logic [DATA_W-1:0]   n_packed;

  lwin_decode #(
    .SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .NUM_SETS(NUM_SETS), .SET_W(SET_W)
  ) u_decode (
    .sel(sel), .mt_en(mt_en), .mf_en(mf_en),
    .op_mt(op_mt), .op_mf(op_mf), .set_idx(set_idx), .illegal(illegal)
  );

  assign do_mt    = mt_en && !illegal;
  assign do_mf    = mf_en && !illegal;
  assign addr     = wdata[ADDR_W-1:0];
  assign cur_data = data_q[set_idx];

  lwin_store #(.W(NARROW_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_narrow (
    .clk(clk), .rst(rst),
    .wr_en(do_mt && op_mt == LW_NWR),
    .wr_addr(addr), .wr_data(cur_data[NARROW_W-1:0]),
    .rd_addr(addr), .rd_data(n_rd)
  );

  lwin_store #(.W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wide (
    .clk(clk), .rst(rst),
    .wr_en(do_mt && op_mt == LW_WWR),
    .wr_addr(addr), .wr_data(cur_data),
    .rd_addr(addr), .rd_data(w_rd)
  );

  lwin_narrow_pack #(.NARROW_W(NARROW_W), .DATA_W(DATA_W)) u_pack (
    .raw(n_rd), .packed_word(n_packed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) data_q[s] <= '0;
    end else if (do_mt) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (set_idx == SET_W'(s)) begin
          case (op_mt)
            LW_DATA: data_q[s] <= wdata;
            LW_NRD:  data_q[s] <= n_packed;
            LW_WRD:  data_q[s] <= w_rd;
            default: data_q[s] <= data_q[s];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= STATUS_RESET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      rvalid      <= 1'b0;
      illegal_sel <= 1'b0;
    end else begin
      rvalid      <= do_mf;
      illegal_sel <= illegal;
      if (do_mf) rdata <= (op_mf == LW_STAT) ? status_q : cur_data;
    end
  end
endmodule

// File: rtl/lwin_checker.sv
module lwin_checker #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 36,
  parameter int SEL_W    = 12,
  parameter logic [SEL_W-1:0]  SEL_BASE     = 12'h400,
  parameter logic [DATA_W-1:0] STATUS_RESET = 64'd1
) (
  input logic              clk,
  input logic              rst,
  input logic              mt_en,
  input logic              mf_en,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              illegal_sel,
  input logic [DATA_W-1:0] data0
);
  assert_status_read_R8: assert property (@(posedge clk) disable iff (rst)
    (mf_en && sel == SEL_BASE) |=> (rvalid && rdata == STATUS_RESET));

  assert_narrow_parity_R4: assert property (@(posedge clk) disable iff (rst)
    (mt_en && sel == SEL_BASE) |=>
      (data0[DATA_W-1:NARROW_W+1] == '0 && (^data0[NARROW_W:0]) == 1'b0));

  assert_data_load_R2: assert property (@(posedge clk) disable iff (rst)
    (mt_en && sel == SEL_BASE + 2) |=> (data0 == $past(wdata)));

  assert_rvalid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(mf_en));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> $stable(rdata));

  assert_illegal_stable_R10: assert property (@(posedge clk) disable iff (rst)
    illegal_sel |-> ($stable(data0) && !rvalid));

  assert_writeonly_mf_R13: assert property (@(posedge clk) disable iff (rst)
    (mf_en && sel == SEL_BASE + 1) |=> illegal_sel);
endmodule

bind lwin_top lwin_checker #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .SEL_W(SEL_W),
  .SEL_BASE(SEL_BASE), .STATUS_RESET(STATUS_RESET)
) u_lwin_checker (
  .clk(clk), .rst(rst), .mt_en(mt_en), .mf_en(mf_en), .sel(sel),
  .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .illegal_sel(illegal_sel),
  .data0(data_q[0])
);

// File: tb/test_lwin_top.sv
module test_lwin_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mt_en = 1'b0;
  logic        mf_en = 1'b0;
  logic [11:0] sel = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rvalid;
  logic        illegal_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [35:0] nm [DEPTH];
  logic [63:0] wm [DEPTH];

  always #10 clk = ~clk;

  lwin_top i_lwin_top (
    .clk(clk), .rst(rst), .mt_en(mt_en), .mf_en(mf_en), .sel(sel),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .illegal_sel(illegal_sel)
  );

  function automatic logic [11:0] s_of(int set, int fn);
    return 12'(12'h400 + set * 8 + fn);
  endfunction

  function automatic logic [63:0] npack(logic [35:0] v);
    logic [63:0] r;
    r = {28'd0, v};
    r[36] = ($countones(v) % 2) == 1;
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_mt(logic [11:0] s, logic [63:0] v);
    sel = s; wdata = v; mt_en = 1'b1;
    @(negedge clk);
    mt_en = 1'b0;
  endtask

  task automatic do_mf(logic [11:0] s, logic [63:0] exp, string tag);
    sel = s; mf_en = 1'b1;
    @(negedge clk);
    mf_en = 1'b0;
    check({tag, " rvalid"}, 64'(rvalid), 64'd1);
    check({tag, " rdata"}, rdata, exp);
  endtask

  task automatic do_mf_bad(logic [11:0] s, logic [63:0] keep, string tag);
    sel = s; mf_en = 1'b1;
    @(negedge clk);
    mf_en = 1'b0;
    check({tag, " illegal"}, 64'(illegal_sel), 64'd1);
    check({tag, " no rvalid"}, 64'(rvalid), 64'd0);
    check({tag, " rdata kept"}, rdata, keep);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rdata", rdata, 64'd0);
    check("R9 reset rvalid", 64'(rvalid), 64'd0);
    check("R9 reset illegal", 64'(illegal_sel), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R8: status word after reset; R2 / R11 data registers start at zero
    do_mf(12'h400, 64'd1, "R8 status");
    do_mf(12'h402, 64'd0, "R2 set0 reset");
    do_mf(12'h40A, 64'd0, "R11 set1 reset");

    // R7: unwritten entries read zero
    do_mt(12'h400, 64'd5);
    do_mf(12'h402, 64'd0, "R7 narrow empty");
    do_mt(12'h40C, 64'd7);
    do_mf(12'h40A, 64'd0, "R7 wide empty");

    // R11 and R2: independent data registers
    do_mt(12'h402, 64'h1111_2222_3333_4444);
    do_mt(12'h40A, 64'hAAAA_BBBB_CCCC_DDDD);
    do_mf(12'h402, 64'h1111_2222_3333_4444, "R11 set0");
    do_mf(12'h40A, 64'hAAAA_BBBB_CCCC_DDDD, "R11 set1");
    do_mf(12'h400, 64'd1, "R8 alias not data");

    // R6: wide write leaves narrow entry empty
    do_mt(12'h402, 64'hDEAD_BEEF_0BAD_F00D);
    do_mt(12'h405, 64'd2);
    do_mt(12'h400, 64'd2);
    do_mf(12'h402, 64'd0, "R6 narrow untouched");
    do_mt(12'h404, 64'd2);
    do_mf(12'h402, 64'hDEAD_BEEF_0BAD_F00D, "R5 wide full");

    // R10: illegal move-to changes nothing
    do_mt(12'h402, 64'h0123_4567_89AB_CDEF);
    do_mt(12'h403, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 illegal 0x403", 64'(illegal_sel), 64'd1);
    check("R10 no rvalid", 64'(rvalid), 64'd0);
    do_mt(12'h406, 64'd0);
    check("R10 illegal 0x406", 64'(illegal_sel), 64'd1);
    do_mt(12'h410, 64'd0);
    check("R10 illegal 0x410", 64'(illegal_sel), 64'd1);
    do_mt(12'h3FF, 64'd0);
    check("R10 illegal 0x3FF", 64'(illegal_sel), 64'd1);
    @(negedge clk);
    check("R10 illegal pulse drops", 64'(illegal_sel), 64'd0);
    check("R9 rvalid pulse drops", 64'(rvalid), 64'd0);
    do_mf(12'h402, 64'h0123_4567_89AB_CDEF, "R10 data kept");

    // R13: move-from on write-only or unmapped selectors
    do_mf_bad(12'h401, 64'h0123_4567_89AB_CDEF, "R13 0x401");
    do_mf_bad(12'h404, 64'h0123_4567_89AB_CDEF, "R13 0x404");
    do_mf_bad(12'h408, 64'h0123_4567_89AB_CDEF, "R13 0x408");
    do_mf_bad(12'h40D, 64'h0123_4567_89AB_CDEF, "R13 0x40D");

    // R1 R3 R5 R9: fill every entry via alternating sets
    for (int a = 0; a < DEPTH; a++) begin
      logic [63:0] nv, wv;
      int s;
      s  = a % 2;
      nv = 64'((a + 1) * 64'h9E37_79B9_7F4A_7C15) | 64'hF000_0000_0000_0000;
      wv = 64'((a + 3) * 64'hC2B2_AE3D_27D4_EB4F);
      do_mt(s_of(s, 2), nv);
      do_mt(s_of(s, 1), 64'(a));
      do_mt(s_of(s, 2), wv);
      do_mt(s_of(s, 5), 64'(a));
      nm[a] = nv[35:0];
      wm[a] = wv;
      do_mt(s_of(1 - s, 4), 64'(a));
      do_mf(s_of(1 - s, 2), wv, "R9 R5 back-to-back wide");
    end

    // R3 R4 R1: read every narrow and wide entry through the other set
    for (int a = 0; a < DEPTH; a++) begin
      int s;
      s = 1 - (a % 2);
      do_mt(s_of(s, 0), 64'(a));
      do_mf(s_of(s, 2), npack(nm[a]), "R4 R3 narrow readback");
      do_mt(s_of(s, 4), 64'(a));
      do_mf(s_of(s, 2), wm[a], "R5 R1 wide readback");
    end

    // R12: index from low address bits
    do_mt(12'h402, 64'hFFFF_FFF5_5555_5555);
    do_mt(12'h401, 64'(3 + DEPTH));
    do_mt(12'h408, 64'd3);
    do_mf(12'h40A, npack(36'h5_5555_5555), "R12 narrow alias");
    do_mt(12'h40A, 64'h0F0F_0F0F_1234_5678);
    do_mt(12'h40D, 64'(5 + 2 * DEPTH));
    do_mt(12'h404, 64'(5 + 7 * DEPTH));
    do_mf(12'h402, 64'h0F0F_0F0F_1234_5678, "R12 wide alias");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule